// File: doc/BRIEF.md
# Selectable-Source Clock Divider Bank with Freeze

This block picks one of two incoming clocks and derives four related clocks from it. The divided outputs come from a single down-counter that runs on the chosen clock, so every ratio shares the same rising edges. Output A carries either the chosen clock itself or that clock halved. Outputs B, C and D carry the clock divided by 2, 4 and 8. Each output is driven as a group of identical copies, so several loads can take it without skew between them.

A freeze request is taken in only on the falling edge of the chosen clock. While the captured freeze is high, the counter holds its value and the pass-through path on A stays low. When the request drops, the following falling edge releases the counter, and counting carries on from the held value. Because the gate changes only while the clock is low, no output high pulse can be shortened.

An active-low reset acts at once and drives every output low. Once reset is released, the block waits for a falling edge before the counter may run. All outputs then rise together on the next rising edge. Every pin is a plain control or clock line. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `clkdiv_bank`

## Requirements
- R1: `clk_sel` = 0 runs the block from `clk_a`, and `clk_sel` = 1 runs it from `clk_b`. The choice is combinational.
- R2: With `div_a_sel` = 0, `out_a` follows the selected clock while the block is running. With `div_a_sel` = 1, `out_a` carries the divide-by-2 waveform, identical to `out_b`.
- R3: `out_b`, `out_c` and `out_d` toggle every 1, 2 and 4 active rising edges, giving divide-by-2, 4 and 8. All three rise on the same edge: the first active edge after reset, and every eighth active edge after it.
- R4: Each output bus holds COPIES (default 2) identical copies of its waveform.
- R5: `freeze` is sampled only on the falling edge of the selected clock. A pulse that starts and ends within one low phase has no effect on the count.
- R6: If `freeze` is high at a falling edge, no counting happens on the following rising edges. `out_b`, `out_c` and `out_d` hold their levels, and the pass-through `out_a` stays low.
- R7: After `freeze` is low at a falling edge, the next rising edge advances the count by one step from the held value, keeping the phase relation of R3.
- R8: `rst_n` = 0 forces all outputs low immediately, without waiting for a clock edge.
- R9: After `rst_n` rises, outputs stay low until the first rising edge that follows a falling edge. On that rising edge all outputs go high.
- R10: While `div_a_sel` = 0 and the clock source is steady, no high pulse on `out_a` is shorter than half a period of the selected clock, even when freeze is applied or removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock source 0 |
| clk_b | input | 1 | Clock source 1 |
| clk_sel | input | 1 | Source choice (0 = clk_a, 1 = clk_b) |
| div_a_sel | input | 1 | Output A ratio (0 = pass-through, 1 = divide by 2) |
| freeze | input | 1 | Freeze request, taken on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_a | output | COPIES | Output A copies |
| out_b | output | COPIES | Divide-by-2 copies |
| out_c | output | COPIES | Divide-by-4 copies |
| out_d | output | COPIES | Divide-by-8 copies |

## Verification
The divided outputs move on the rising edge, so the bench samples them 2 ns after each rising edge of the selected clock, while the clock is still high. It compares them against an edge count k, from which each ratio's level follows directly. A freeze change is driven while the clock is high and takes effect at the falling edge that follows; the first rising edge after that falling edge is the first one affected, and the checks count edges from that point. Reset is checked 1 ns after it is driven, because its effect is immediate. Pulse widths on `out_a` are timed from each rise to the matching fall.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // number of binary divide stages (÷2, ÷4, ÷8)
  localparam int unsigned DIV_STAGES = 3;
  localparam int unsigned B_BIT = 0;
  localparam int unsigned C_BIT = 1;
  localparam int unsigned D_BIT = 2;

  // state held by the falling-edge control flops
  typedef struct packed {
    logic armed;   // a falling edge has been seen since reset
    logic hold;    // captured freeze request
    logic run;     // armed and not held
  } neg_ctl_t;
endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  output logic clk_o
);
  always_comb begin
    clk_o = sel ? clk_b : clk_a;
  end
endmodule

// File: rtl/negedge_ctrl.sv
module negedge_ctrl
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freeze_req,
  output neg_ctl_t ctl
);
  logic armed_q;
  logic hold_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      hold_q  <= freeze_req;
    end
  end

  always_comb begin
    ctl.armed = armed_q;
    ctl.hold  = hold_q;
    ctl.run   = armed_q & ~hold_q;
  end

  // R9
  armed_sticky_chk: assert property (@(negedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  // down-count: 0 wraps to all ones, so every bit rises on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> cnt_q == $past(cnt_q) - ONE);

  // R9
  idle_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> cnt_q == '0);
endmodule

// File: rtl/copy_fanout.sv
module copy_fanout #(
  parameter int unsigned COPIES = 2
) (
  input  logic              d,
  output logic [COPIES-1:0] q
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign q[i] = d;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned COPIES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              clk_sel,
  input  logic              div_a_sel,
  input  logic              freeze,
  input  logic              rst_n,
  output logic [COPIES-1:0] out_a,
  output logic [COPIES-1:0] out_b,
  output logic [COPIES-1:0] out_c,
  output logic [COPIES-1:0] out_d
);
  localparam int unsigned NOUT = 4;

  logic                  clk_int;
  neg_ctl_t              ctl;
  logic [DIV_STAGES-1:0] cnt;
  logic                  pass_clk;
  logic [NOUT-1:0]       src;

  clk_src_sel u_sel (
    .clk_a (clk_a),
    .clk_b (clk_b),
    .sel   (clk_sel),
    .clk_o (clk_int)
  );

  negedge_ctrl u_neg (
    .clk        (clk_int),
    .rst_n      (rst_n),
    .freeze_req (freeze),
    .ctl        (ctl)
  );

  div_counter #(.W(DIV_STAGES)) u_cnt (
    .clk     (clk_int),
    .rst_n   (rst_n),
    .armed_i (ctl.armed),
    .run_i   (ctl.run),
    .cnt_o   (cnt)
  );

  // gate changes only while the clock is low: no shortened high pulse
  assign pass_clk = clk_int & ctl.run;

  always_comb begin
    src[0] = div_a_sel ? cnt[B_BIT] : pass_clk;
    src[1] = cnt[B_BIT];
    src[2] = cnt[C_BIT];
    src[3] = cnt[D_BIT];
  end

  logic [COPIES-1:0] fan [NOUT];

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    copy_fanout #(.COPIES(COPIES)) u_fan (
      .d (src[o]),
      .q (fan[o])
    );
  end

  assign out_a = fan[0];
  assign out_b = fan[1];
  assign out_c = fan[2];
  assign out_d = fan[3];

  // R3
  ratio_align_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(out_d[0]) |-> ($rose(out_c[0]) && $rose(out_b[0])));

  // R8
  always_ff @(posedge clk_int) begin
    if (!rst_n) begin
      reset_low_chk: assert (out_b == '0 && out_c == '0 && out_d == '0);
    end
  end
endmodule

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;
  localparam int CP = 2;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic clk_sel = 1'b0;
  logic div_a_sel = 1'b0;
  logic freeze = 1'b0;
  logic rst_n = 1'b0;
  logic [CP-1:0] out_a, out_b, out_c, out_d;

  always #5 clk_a = ~clk_a;   // 100 MHz
  always #7 clk_b = ~clk_b;

  clkdiv_bank #(.COPIES(CP)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .clk_sel(clk_sel), .div_a_sel(div_a_sel),
    .freeze(freeze), .rst_n(rst_n),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  int vec = 0;
  int bad = 0;
  int k = 0;
  bit done = 0;
  bit mon_en = 0;
  realtime t_rise = 0.0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_dcb(int n);
    logic b, c, d;
    b = ((n - 1) % 2) == 0;
    c = ((n - 1) % 4) < 2;
    d = ((n - 1) % 8) < 4;
    return {d, c, b};
  endfunction

  task automatic step();
    if (clk_sel) @(posedge clk_b); else @(posedge clk_a);
    #2;
  endtask

  task automatic nstep();
    if (clk_sel) @(negedge clk_b); else @(negedge clk_a);
    #2;
  endtask

  // R10: high pulse width monitor on out_a
  always @(posedge out_a[0]) t_rise = $realtime;
  always @(negedge out_a[0]) begin
    if (mon_en && rst_n) begin
      vec++;
      if ($realtime - t_rise < 4.9) begin
        bad++;
        $display("FAIL R10 runt pulse: actual=%0t expected>=5ns", $realtime - t_rise);
      end
    end
  end

  task automatic do_reset(logic sel);
    mon_en = 0;
    rst_n = 1'b0;
    freeze = 1'b0;
    clk_sel = sel;
    step(); step();
    check("R8 outputs low in reset", {out_a, out_b, out_c, out_d}, '0);
    rst_n = 1'b1;           // released while the clock is high
    #1;
    check("R9 low before falling edge", {out_a, out_b, out_c, out_d}, '0);
    step();
    k = 1;
    check("R9 all high on first armed edge", {out_d[0], out_c[0], out_b[0]}, 3'b111);
    check("R9 out_a high on first armed edge", out_a[0], 1'b1);
    mon_en = 1;
  endtask

  task automatic t_ratios(int n);
    for (int i = 0; i < n; i++) begin
      step();
      k++;
      check("R3 ratio pattern", {out_d[0], out_c[0], out_b[0]}, exp_dcb(k));
      check("R4 copies equal", {out_b[1], out_c[1], out_d[1]}, {out_b[0], out_c[0], out_d[0]});
    end
  endtask

  task automatic t_pass(int n);
    for (int i = 0; i < n; i++) begin
      step();
      k++;
      check("R2 pass-through high", out_a, {CP{1'b1}});
      nstep();
      check("R2 pass-through low", out_a, '0);
    end
  endtask

  task automatic t_half(int n);
    mon_en = 0;
    div_a_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      k++;
      check("R2 divide-by-2 on out_a", out_a[0], exp_dcb(k)[0]);
    end
    div_a_sel = 1'b0;
    step();
    k++;
    mon_en = 1;
  endtask

  task automatic t_freeze();
    logic [2:0] held;
    step();
    k++;
    held = {out_d[0], out_c[0], out_b[0]};
    freeze = 1'b1;          // clock high: captured at next falling edge
    for (int i = 0; i < 5; i++) begin
      step();
      check("R6 divided outputs held", {out_d[0], out_c[0], out_b[0]}, held);
      check("R6 pass-through low while frozen", out_a[0], 1'b0);
    end
    freeze = 1'b0;
    step();
    k++;
    check("R7 resume from held count", {out_d[0], out_c[0], out_b[0]}, exp_dcb(k));
    check("R7 pass-through back", out_a[0], 1'b1);
    t_ratios(4);
  endtask

  task automatic t_ignored();
    step();
    k++;
    if (clk_sel) @(negedge clk_b); else @(negedge clk_a);
    #1 freeze = 1'b1;
    #2 freeze = 1'b0;       // gone before the next falling edge
    step();
    k++;
    check("R5 low-phase pulse ignored", {out_d[0], out_c[0], out_b[0]}, exp_dcb(k));
    step();
    k++;
    check("R5 count continues", {out_d[0], out_c[0], out_b[0]}, exp_dcb(k));
  endtask

  task automatic t_reset_mid();
    mon_en = 0;
    step();
    nstep();
    #1 rst_n = 1'b0;
    #1;
    check("R8 immediate reset", {out_a, out_b, out_c, out_d}, '0);
    step();
    check("R8 held in reset", {out_a, out_b, out_c, out_d}, '0);
  endtask

  initial begin
    do_reset(1'b0);
    t_ratios(16);
    t_pass(4);
    t_half(8);
    t_freeze();
    t_ignored();
    t_reset_mid();
    do_reset(1'b1);         // R1: source B
    t_ratios(10);
    t_pass(3);
    t_freeze();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule